// File: doc/BRIEF.md
# Soft-Edge Slow PWM Heater Driver

This block switches a heater load with a slow pulse-width modulated drive, about 30 Hz at a 16 MHz clock with the default parameters. A hard on/off edge at that rate makes the load click audibly. To avoid this, each edge is replaced by a short burst of fast PWM whose duty climbs from low to full on the way up and drops back on the way down. While the output is steadily high or steadily low, the control sequence advances at one eighth of the ramp rate. This keeps the base period long.

A 7-bit duty request is doubled into an 8-bit level and latched once, at the start of every slow cycle. A hold input freezes the sequence while it is waiting to start a cycle or while the output is steadily on. This gives a quiet, constant drive level for a short time. The current sequencer state is brought out as a 3-bit debug code.

Top module: `soft_edge_pwm`

## Requirements
- R1: Synchronous reset (active high) clears the drive output to 0 and puts the sequencer in the start state, which shows on `state_o` as code 0. The codes are: 0 start, 1 steady off, 2 arm-rise, 3 rise ramp, 4 settle-on, 5 steady on, 6 fall ramp, 7 settle-off.
- R2: The doubled request `{duty_req,0}` is latched only on the start-state tick. A request change later in the cycle does not alter that cycle's on-time; it takes effect from the next cycle.
- R3: A zero request latched at the start tick keeps the sequencer in the start state (code 0), with the drive low.
- R4: The drive is low in the start, steady-off, arm-rise and settle-off states, and high in settle-on and steady on, with no pulses. In steady operation with doubled request d (0 < d < 2^(DUTY_W+1)-3), each cycle holds the drive high for STEPS*F + F + d*S clocks, where F = 2^FAST_W, S = F*2^DIV_W and STEPS = 2^STEP_W.
- R5: Each ramp spans STEPS fast periods of F clocks. In rise step k (k = 1..STEPS) the drive is high for the first k*F/STEPS clocks of the period. In fall step k it is low for the first k*F/STEPS clocks and high for the rest.
- R6: The start, steady-off, arm-rise and steady-on states advance once per S clocks. The ramp, settle-on and settle-off states advance once per F clocks. Each arm and settle state lasts exactly one tick. With a nonzero request after reset, the drive first goes high 3*S+1 clocks after reset is released.
- R7: In steady operation with a non-zero, non-full request, the cycle length is (2^(DUTY_W+1)+2)*S + (2*STEPS+2)*F clocks, and it contains exactly 2*STEPS-1 rising edges of the drive.
- R8: While the live doubled request is 2^(DUTY_W+1)-3 or more, steady on is never left, so the drive stays constantly high.
- R9: With hold asserted in the start state, the sequencer stays there (code 0) and the drive stays low. Once hold is released, it resumes within one start tick.
- R10: With hold asserted in steady on, the sequencer stays there with the drive high and its slow count frozen. Once hold is released, the cycle completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty_req | input | DUTY_W | Requested duty, doubled internally |
| hold | input | 1 | Freeze sequencer in start or steady-on state |
| drive_o | output | 1 | Registered heater drive |
| state_o | output | 3 | Sequencer state code (debug) |

## Verification
Several duty requests are applied, each held long enough to reach steady operation. These include the smallest nonzero value, mid values, the largest request below the full-on threshold, the full-on value and zero. For each one, the high time and the rising-edge count are measured over one exact cycle length. These measurements separate an off-by-one in either slow-count comparison, a wrong threshold, and a broken ramp or a missing transition tick. The individual high-pulse widths across one rise and one fall show the ramp compare steps and the fall polarity. A request changed in the middle of the on phase shows whether the duty is latched at the cycle start. Both hold states are exercised, each from a known phase.

// File: rtl/sep_pkg.sv
package sep_pkg;

    typedef enum logic [2:0] {
        ST_START      = 3'd0,
        ST_OFF        = 3'd1,
        ST_ARM_RISE   = 3'd2,
        ST_RISE       = 3'd3,
        ST_SETTLE_ON  = 3'd4,
        ST_ON         = 3'd5,
        ST_FALL       = 3'd6,
        ST_SETTLE_OFF = 3'd7
    } sep_state_e;

    typedef struct packed {
        logic off_exit;   // incremented count no longer above latched duty
        logic on_exit;    // incremented count reached latched duty
        logic full_req;   // live doubled request at or above full threshold
        logic req_zero;   // live request is zero
    } sep_duty_flags_t;

    function automatic logic sep_is_fast(input sep_state_e s);
        return (s == ST_RISE) || (s == ST_SETTLE_ON) ||
               (s == ST_FALL) || (s == ST_SETTLE_OFF);
    endfunction

    function automatic logic sep_is_ramp(input sep_state_e s);
        return (s == ST_RISE) || (s == ST_FALL);
    endfunction

    function automatic logic sep_is_high(input sep_state_e s);
        return (s == ST_SETTLE_ON) || (s == ST_ON);
    endfunction

endpackage

// File: rtl/sep_timebase.sv
module sep_timebase #(
    parameter int FAST_W = 8,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_mode,
    output logic              tick,
    output logic [FAST_W-1:0] phase
);
    localparam int TW = FAST_W + DIV_W;
    localparam logic [TW-1:0] FAST_LIM = TW'((1 << FAST_W) - 1);
    localparam logic [TW-1:0] SLOW_LIM = '1;

    logic [TW-1:0] tcnt_q;

    assign tick  = (tcnt_q == (fast_mode ? FAST_LIM : SLOW_LIM));
    assign phase = tcnt_q[FAST_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)       tcnt_q <= '0;
        else if (tick) tcnt_q <= '0;
        else           tcnt_q <= tcnt_q + TW'(1);
    end

    // fast-rate states are only ever entered on a tick, so the count starts at zero
    AST_FAST_WINDOW: assert property (@(posedge clk) disable iff (rst)
        fast_mode |-> (tcnt_q <= FAST_LIM)); // R6

endmodule

// File: rtl/sep_duty_track.sv
module sep_duty_track import sep_pkg::*; #(
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] req,
    input  logic              capture,
    input  logic              step,
    output sep_duty_flags_t   flags
);
    localparam int DW1 = DUTY_W + 1;
    localparam logic [DW1-1:0] FULL_THR = DW1'((1 << DW1) - 3);

    logic [DW1-1:0] duty_q;
    logic [DW1-1:0] cnt_q;
    logic [DW1-1:0] cnt_inc;
    logic [DW1-1:0] req2;

    assign req2    = {req, 1'b0};
    assign cnt_inc = cnt_q + DW1'(1);

    always_comb begin
        flags.off_exit = (cnt_inc <= duty_q);
        flags.on_exit  = (cnt_inc >= duty_q);
        flags.full_req = (req2 >= FULL_THR);
        flags.req_zero = (req == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (capture) duty_q <= req2;
            if (step)    cnt_q  <= cnt_inc;
        end
    end

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(duty_q)); // R2

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/sep_ramp.sv
module sep_ramp #(
    parameter int FAST_W = 8,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic              invert,
    input  logic [FAST_W-1:0] phase,
    output logic              level,
    output logic              last
);
    localparam int SH = FAST_W - STEP_W;

    logic [STEP_W-1:0] idx_q;
    logic [FAST_W:0]   step_no;
    logic [FAST_W:0]   cmp;
    logic              below;

    always_comb begin
        step_no = (FAST_W+1)'(idx_q) + (FAST_W+1)'(1);
        cmp     = step_no << SH;
        below   = ({1'b0, phase} < cmp);
        level   = invert ? !below : below;
        last    = &idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst)               idx_q <= '0;
        else if (load)         idx_q <= '0;
        else if (adv && !last) idx_q <= idx_q + STEP_W'(1);
    end

    // the final step covers the whole fast period
    AST_LAST_STEP_FULL: assert property (@(posedge clk) disable iff (rst)
        (last && !load) |-> (level == !invert)); // R5

endmodule

// File: rtl/soft_edge_pwm.sv
module soft_edge_pwm import sep_pkg::*; #(
    parameter int FAST_W = 8,
    parameter int DIV_W  = 3,
    parameter int STEP_W = 4,
    parameter int DUTY_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic              hold,
    output logic              drive_o,
    output logic [2:0]        state_o
);
    sep_state_e        st_q, st_n;
    logic              tick;
    logic [FAST_W-1:0] phase;
    sep_duty_flags_t   flags;
    logic              cap, step;
    logic              ramp_level, ramp_last;
    logic              level;

    sep_timebase #(.FAST_W(FAST_W), .DIV_W(DIV_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .fast_mode (sep_is_fast(st_q)),
        .tick      (tick),
        .phase     (phase)
    );

    sep_duty_track #(.DUTY_W(DUTY_W)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .req     (duty_req),
        .capture (cap),
        .step    (step),
        .flags   (flags)
    );

    sep_ramp #(.FAST_W(FAST_W), .STEP_W(STEP_W)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .load   (!sep_is_ramp(st_q)),
        .adv    (tick && sep_is_ramp(st_q)),
        .invert (st_q == ST_FALL),
        .phase  (phase),
        .level  (ramp_level),
        .last   (ramp_last)
    );

    always_comb begin
        st_n = st_q;
        cap  = 1'b0;
        step = 1'b0;
        unique case (st_q)
            ST_START: if (tick && !hold) begin
                cap = 1'b1;
                if (!flags.req_zero) st_n = ST_OFF;
            end
            ST_OFF: if (tick) begin
                step = 1'b1;
                if (flags.off_exit) st_n = ST_ARM_RISE;
            end
            ST_ARM_RISE:  if (tick) st_n = ST_RISE;
            ST_RISE:      if (tick && ramp_last) st_n = ST_SETTLE_ON;
            ST_SETTLE_ON: if (tick) st_n = ST_ON;
            ST_ON: if (tick && !hold) begin
                step = 1'b1;
                if (flags.on_exit && !flags.full_req) st_n = ST_FALL;
            end
            ST_FALL:       if (tick && ramp_last) st_n = ST_SETTLE_OFF;
            ST_SETTLE_OFF: if (tick) st_n = ST_START;
            default:       st_n = ST_START;
        endcase
    end

    always_comb begin
        if (sep_is_ramp(st_q)) level = ramp_level;
        else                   level = sep_is_high(st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_START;
            drive_o <= 1'b0;
        end else begin
            st_q    <= st_n;
            drive_o <= level;
        end
    end

    assign state_o = st_q;

    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!drive_o && state_o == 3'd0)); // R1

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START && tick && duty_req == '0) |=> (st_q == ST_START)); // R3

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_OFF) |=> !drive_o); // R4

    AST_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON) |=> drive_o); // R4

    AST_ARM_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARM_RISE && tick) |=> (st_q == ST_RISE)); // R6

    AST_SETTLE_ONE_TICK: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SETTLE_OFF && tick) |=> (st_q == ST_START)); // R6

    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON && flags.full_req) |=> (st_q == ST_ON)); // R8

    AST_HOLD_START: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_START && hold) |=> (st_q == ST_START && !drive_o)); // R9

    AST_HOLD_ON: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ON && hold) |=> (st_q == ST_ON && drive_o)); // R10

endmodule

// File: tb/soft_edge_pwm_test.sv
module soft_edge_pwm_test;
    localparam int FW = 4;
    localparam int DV = 1;
    localparam int SW = 2;
    localparam int DW = 5;
    localparam int F  = 1 << FW;
    localparam int S  = F << DV;
    localparam int STEPS = 1 << SW;
    localparam int M  = 1 << (DW + 1);
    localparam int L  = (M + 2) * S + (2 * STEPS + 2) * F;

    localparam int NV = 6;
    localparam int TBL_REQ [NV] = '{1, 5, 16, 30, 31, 0};
    localparam int TBL_RISES [NV] = '{2*STEPS-1, 2*STEPS-1, 2*STEPS-1, 2*STEPS-1, 0, 0};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hold = 1'b0;
    logic [DW-1:0] req = '0;
    logic          drive;
    logic [2:0]    st;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    soft_edge_pwm #(.FAST_W(FW), .DIV_W(DV), .STEP_W(SW), .DUTY_W(DW)) uut (
        .clk(clk), .rst(rst), .duty_req(req), .hold(hold),
        .drive_o(drive), .state_o(st)
    );

    function automatic int exp_high(input int r);
        if (r == 0) return 0;
        if (2 * r >= M - 3) return L;
        return F * STEPS + F + 2 * r * S;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit h, input int r);
        rst = 1'b1; hold = h; req = DW'(r);
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic window(input int n, output int hi, output int rises);
        logic prev;
        prev = drive; hi = 0; rises = 0;
        repeat (n) begin
            @(negedge clk);
            if (drive) hi++;
            if (drive && !prev) rises++;
            prev = drive;
        end
    endtask

    task automatic high_run(output int len);
        while (drive !== 1'b1) @(negedge clk);
        len = 0;
        while (drive === 1'b1) begin len++; @(negedge clk); end
    endtask

    task automatic sync_off();
        int lowc;
        lowc = 0;
        while (lowc <= F) begin
            @(negedge clk);
            if (drive) lowc = 0; else lowc++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, rs, len, cnt;
        int ramp_exp [3];
        ramp_exp = '{F/STEPS, 2*F/STEPS, 3*F/STEPS};

        // R1: reset state
        do_reset(1'b0, 10);
        chk(drive == 1'b0, "R1 drive low at reset", int'(drive), 0);
        chk(st == 3'd0, "R1 start code at reset", int'(st), 0);

        // R6: three slow ticks before the first rise, plus the output register
        cnt = 0;
        while (!drive && cnt < 1000) begin @(negedge clk); cnt++; end
        chk(cnt == 3 * S + 1, "R6 first rise timing", cnt, 3 * S + 1);

        // R5 ramp widths and R2 latch-at-start, duty 10 -> doubled 20
        sync_off();
        for (int k = 0; k < 3; k++) begin
            high_run(len);
            chk(len == ramp_exp[k], "R5 rise step width", len, ramp_exp[k]);
        end
        while (drive !== 1'b1) @(negedge clk);
        len = 0;
        while (drive === 1'b1) begin
            len++;
            if (len == 3 * F) req = DW'(5);
            @(negedge clk);
        end
        chk(len == 2 * F + 20 * S, "R2 on run keeps latched duty", len, 2 * F + 20 * S);
        for (int k = 2; k >= 0; k--) begin
            high_run(len);
            chk(len == ramp_exp[k], "R5 fall step width", len, ramp_exp[k]);
        end
        for (int k = 0; k < 3; k++) high_run(len);
        high_run(len);
        chk(len == 2 * F + 10 * S, "R2 new duty from next cycle", len, 2 * F + 10 * S);

        // R4 R7 R8 R3: table of requests in steady operation
        for (int i = 0; i < NV; i++) begin
            req = DW'(TBL_REQ[i]);
            repeat (3 * L) @(negedge clk);
            window(L, hi, rs);
            chk(hi == exp_high(TBL_REQ[i]),
                (TBL_REQ[i] == 31) ? "R8 full high time" :
                (TBL_REQ[i] == 0)  ? "R3 zero high time" : "R4 high time per cycle",
                hi, exp_high(TBL_REQ[i]));
            chk(rs == TBL_RISES[i], "R7 rising edges per cycle", rs, TBL_RISES[i]);
        end
        chk(st == 3'd0, "R3 stays in start code", int'(st), 0);

        // R10: hold during steady on
        req = DW'(10);
        repeat (3 * L) @(negedge clk);
        sync_off();
        while (drive !== 1'b1) @(negedge clk);
        repeat (3 * F) @(negedge clk);
        hold = 1'b1;
        window(2 * L, hi, rs);
        chk(hi == 2 * L, "R10 drive frozen high", hi, 2 * L);
        chk(st == 3'd5, "R10 held in on code", int'(st), 5);
        hold = 1'b0;
        cnt = 0;
        while (drive && cnt < 2 * L) begin @(negedge clk); cnt++; end
        chk(cnt <= 20 * S + F, "R10 cycle completes after release", cnt, 20 * S + F);

        // R9: hold in start state from reset
        do_reset(1'b1, 10);
        window(3 * L, hi, rs);
        chk(hi == 0, "R9 drive frozen low", hi, 0);
        chk(st == 3'd0, "R9 held in start code", int'(st), 0);
        hold = 1'b0;
        cnt = 0;
        while (!drive && cnt < 2 * L) begin @(negedge clk); cnt++; end
        chk(cnt >= 2 * S + 1 && cnt <= 3 * S + 1, "R9 resumes after release", cnt, 3 * S + 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule